// File: doc/BRIEF.md
# SPI EEPROM Boot Probe

This block runs once after every reset, and again on each start request, to choose where the chip boots from. It first samples a strap pin that says whether an SPI EEPROM may be present. When that strap is low it decides at once, without touching the SPI pins. When the strap is high it performs one SPI read of four header bytes from address zero, using a two-byte address, and classifies what came back.

A header that matches one of the two full signatures selects SPI boot with 16-bit addressing. The two signatures differ only in the host-protection flag they set. A device that needs a three-byte address treats the first data byte as an extra address byte, so its signature arrives shifted by one byte. The block recognises the shifted three-character pattern in the last three byte lanes, selects 24-bit addressing, and raises a request for a later header re-fetch with three address bytes, because the fourth header byte has not been read yet. Anything else, including an all-ones response from a floating data line, gives the fallback decision: NAND probe when the NAND strap is high, and internal ROM otherwise.

The decision is presented with a one-cycle done pulse. The decision and its flags then stay valid and steady until the next run starts.

Top module: `eeprom_boot_probe`

## Requirements
- R1: If the SPI strap is low when a run starts, the block decides without any SPI activity (chip select stays high, SCK stays low). The decision is NAND probe (code 2) when the NAND strap is high and ROM (code 0) when it is low.
- R2: A probe read is one SPI mode-0 frame with chip select held low throughout. MOSI carries command byte 0x03 and then sixteen zero address bits, MSB first, followed by 32 data clocks. MISO is sampled on the SCK rising edge, and each SCK half period lasts CLK_DIV system clocks.
- R3: A header of bytes 0x56 0x4C 0x53 0x35, first byte received in bits 31:24, gives source SPI (code 1), 24-bit flag 0 and protection flag 1.
- R4: A header of bytes 0x57 0x4C 0x53 0x35 gives source SPI, 24-bit flag 0 and protection flag 0.
- R5: A header that matches neither full signature but whose bytes 1 to 3 are 0x56 0x4C 0x53, whatever byte 0 holds, gives source SPI, 24-bit flag 1, protection flag 1, and the re-fetch request output high.
- R6: Any other header, including 0xFFFFFFFF, gives the fallback decision: NAND probe if the NAND strap was high at the start of the run, ROM otherwise, with both flags and the re-fetch request at 0.
- R7: Done is high for exactly one cycle per run, and in that cycle the valid output is already high. The decision, flags and valid output then hold unchanged until a new run starts.
- R8: A start pulse while idle begins a new run and drops valid until that run's done. Start pulses while a run is busy are ignored, so they cause no second SPI frame and no second done pulse.
- R9: While reset is asserted, chip select is high, SCK is low, and done, valid and busy are low. Reset is applied asynchronously, so a run in progress is abandoned at once.
- R10: After reset is released, a run starts on its own without a start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begins a new run when idle |
| spi_strap_i | input | 1 | High allows the SPI EEPROM attempt |
| nand_strap_i | input | 1 | High selects NAND probe as fallback |
| spi_cs_n_o | output | 1 | SPI chip select, active low |
| spi_sck_o | output | 1 | SPI clock, idle low |
| spi_mosi_o | output | 1 | SPI data to the EEPROM |
| spi_miso_i | input | 1 | SPI data from the EEPROM |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse when the decision is ready |
| valid_o | output | 1 | Decision and flags are valid |
| boot_src_o | output | 2 | 0 ROM, 1 SPI EEPROM, 2 NAND probe |
| addr24_o | output | 1 | EEPROM needs 24-bit addressing |
| prot_o | output | 1 | Protected host flag |
| refetch24_o | output | 1 | Header must be re-read with three address bytes |

## Verification
A wrong bit counter or divider shows up on the SPI pins within the first frame. The command and address bits seen by the bench model would be shifted, or the measured SCK period would be wrong, and every data byte would then land in the wrong lane and give the wrong classification on the next done pulse. A wrong sequencer state shows up within a few cycles as a missing or doubled done pulse, a second chip-select fall, or valid staying high while busy. Byte-lane errors in the classifier show up as a wrong source or wrong flags on the shifted-signature and near-miss headers.

// File: rtl/bprobe_pkg.sv
package bprobe_pkg;

  typedef enum logic [1:0] {
    SRC_ROM  = 2'd0,
    SRC_SPI  = 2'd1,
    SRC_NAND = 2'd2
  } boot_src_e;

  typedef struct packed {
    boot_src_e src;
    logic      addr24;
    logic      prot;
  } boot_dec_t;

  localparam logic [7:0]  RD_CMD    = 8'h03;
  localparam logic [31:0] SIG_PROT  = 32'h564C5335;
  localparam logic [31:0] SIG_OPEN  = 32'h574C5335;
  localparam logic [23:0] SIG_SHIFT = 24'h564C53;

endpackage

// File: rtl/bprobe_rst_sync.sv
module bprobe_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_int_n = sync_q[STAGES-1];

endmodule

// File: rtl/bprobe_spi_rd.sv
module bprobe_spi_rd #(
  parameter int         CLK_DIV   = 4,
  parameter int         ADDR_BITS = 16,
  parameter int         DATA_BITS = 32,
  parameter logic [7:0] CMD       = 8'h03
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go_i,
  output logic                 done_o,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 sck_o,
  output logic                 cs_n_o,
  output logic                 mosi_o,
  input  logic                 miso_i
);

  localparam int TX_BITS = 8 + ADDR_BITS;
  localparam int TOTAL   = TX_BITS + DATA_BITS;
  localparam int CNT_W   = $clog2(TOTAL);
  localparam int DIV_W   = $clog2(CLK_DIV) + 1;

  logic                 act_q, act_d;
  logic                 sck_q, sck_d;
  logic                 done_q, done_d;
  logic [DIV_W-1:0]     div_q, div_d;
  logic [CNT_W-1:0]     bit_q, bit_d;
  logic [TX_BITS-1:0]   tx_q, tx_d;
  logic [DATA_BITS-1:0] rx_q, rx_d;
  logic                 half_end;

  assign half_end = (div_q == DIV_W'(CLK_DIV - 1));

  always_comb begin
    act_d  = act_q;
    sck_d  = sck_q;
    done_d = 1'b0;
    div_d  = div_q;
    bit_d  = bit_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    if (!act_q) begin
      if (go_i) begin
        act_d = 1'b1;
        sck_d = 1'b0;
        div_d = '0;
        bit_d = '0;
        tx_d  = {CMD, {ADDR_BITS{1'b0}}};
      end
    end else if (half_end) begin
      div_d = '0;
      if (!sck_q) begin
        sck_d = 1'b1;
        rx_d  = {rx_q[DATA_BITS-2:0], miso_i};
      end else begin
        sck_d = 1'b0;
        tx_d  = tx_q << 1;
        if (bit_q == CNT_W'(TOTAL - 1)) begin
          act_d  = 1'b0;
          done_d = 1'b1;
        end else begin
          bit_d = bit_q + CNT_W'(1);
        end
      end
    end else begin
      div_d = div_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      act_q  <= act_d;
      sck_q  <= sck_d;
      done_q <= done_d;
      div_q  <= div_d;
      bit_q  <= bit_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
    end
  end

  assign sck_o  = sck_q;
  assign cs_n_o = !act_q;
  assign mosi_o = tx_q[TX_BITS-1];
  assign done_o = done_q;
  assign data_o = rx_q;

  a_r2_sck_low_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sck_o);
  a_r2_mosi_steady_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_q && $past(sck_q)) |-> $stable(mosi_o));
  a_r2_done_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (cs_n_o && !sck_o));

endmodule

// File: rtl/bprobe_classify.sv
module bprobe_classify
  import bprobe_pkg::*;
(
  input  logic [31:0] hdr_i,
  input  logic        nand_i,
  output boot_dec_t   dec_o
);

  logic hit_prot, hit_open, hit_shift;

  assign hit_prot  = (hdr_i == SIG_PROT);
  assign hit_open  = (hdr_i == SIG_OPEN);
  assign hit_shift = (hdr_i[23:0] == SIG_SHIFT);

  always_comb begin
    dec_o.addr24 = 1'b0;
    dec_o.prot   = 1'b0;
    if (hit_prot) begin
      dec_o.src  = SRC_SPI;
      dec_o.prot = 1'b1;
    end else if (hit_open) begin
      dec_o.src  = SRC_SPI;
    end else if (hit_shift) begin
      dec_o.src    = SRC_SPI;
      dec_o.addr24 = 1'b1;
      dec_o.prot   = 1'b1;
    end else begin
      dec_o.src = nand_i ? SRC_NAND : SRC_ROM;
    end
  end

endmodule

// File: rtl/eeprom_boot_probe.sv
module eeprom_boot_probe
  import bprobe_pkg::*;
#(
  parameter int CLK_DIV   = 4,
  parameter int SYNC_STGS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       spi_strap_i,
  input  logic       nand_strap_i,
  output logic       spi_cs_n_o,
  output logic       spi_sck_o,
  output logic       spi_mosi_o,
  input  logic       spi_miso_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       valid_o,
  output logic [1:0] boot_src_o,
  output logic       addr24_o,
  output logic       prot_o,
  output logic       refetch24_o
);

  localparam int ADDR_BITS = 16;
  localparam int DATA_BITS = 32;

  typedef enum logic [1:0] {ST_LAUNCH, ST_XFER, ST_IDLE} st_e;

  logic                 rst_int_n;
  st_e                  st_q, st_d;
  boot_dec_t            dec_q, dec_d, cls_dec;
  logic                 valid_q, valid_d;
  logic                 done_q, done_d;
  logic                 nand_q, nand_d;
  logic                 go;
  logic                 xfer_done;
  logic [DATA_BITS-1:0] hdr;

  bprobe_rst_sync #(.STAGES(SYNC_STGS)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  bprobe_spi_rd #(
    .CLK_DIV   (CLK_DIV),
    .ADDR_BITS (ADDR_BITS),
    .DATA_BITS (DATA_BITS),
    .CMD       (RD_CMD)
  ) u_spi (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .go_i   (go),
    .done_o (xfer_done),
    .data_o (hdr),
    .sck_o  (spi_sck_o),
    .cs_n_o (spi_cs_n_o),
    .mosi_o (spi_mosi_o),
    .miso_i (spi_miso_i)
  );

  bprobe_classify u_cls (
    .hdr_i  (hdr),
    .nand_i (nand_q),
    .dec_o  (cls_dec)
  );

  always_comb begin
    st_d    = st_q;
    dec_d   = dec_q;
    valid_d = valid_q;
    done_d  = 1'b0;
    nand_d  = nand_q;
    go      = 1'b0;
    unique case (st_q)
      ST_LAUNCH: begin
        nand_d = nand_strap_i;
        if (spi_strap_i) begin
          go   = 1'b1;
          st_d = ST_XFER;
        end else begin
          dec_d.src    = nand_strap_i ? SRC_NAND : SRC_ROM;
          dec_d.addr24 = 1'b0;
          dec_d.prot   = 1'b0;
          valid_d      = 1'b1;
          done_d       = 1'b1;
          st_d         = ST_IDLE;
        end
      end
      ST_XFER: begin
        if (xfer_done) begin
          dec_d   = cls_dec;
          valid_d = 1'b1;
          done_d  = 1'b1;
          st_d    = ST_IDLE;
        end
      end
      default: begin
        if (start_i) begin
          valid_d = 1'b0;
          st_d    = ST_LAUNCH;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q    <= ST_LAUNCH;
      dec_q   <= '{src: SRC_ROM, addr24: 1'b0, prot: 1'b0};
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      nand_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      dec_q   <= dec_d;
      valid_q <= valid_d;
      done_q  <= done_d;
      nand_q  <= nand_d;
    end
  end

  assign busy_o      = rst_int_n && (st_q != ST_IDLE);
  assign done_o      = done_q;
  assign valid_o     = valid_q;
  assign boot_src_o  = dec_q.src;
  assign addr24_o    = dec_q.addr24;
  assign prot_o      = dec_q.prot;
  assign refetch24_o = valid_q && dec_q.addr24;

  a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_q |=> !done_q);
  a_r7_done_with_valid: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_q |-> valid_q);
  a_r7_decision_held: assert property (@(posedge clk) disable iff (!rst_int_n)
    (valid_q && $past(valid_q)) |-> $stable(dec_q));
  a_r8_no_valid_while_busy: assert property (@(posedge clk) disable iff (!rst_int_n)
    busy_o |-> !valid_q);
  a_r8_start_ignored_busy: assert property (@(posedge clk) disable iff (!rst_int_n)
    (st_q == ST_XFER && start_i && !xfer_done) |=> (st_q == ST_XFER));
  a_r1_skip_without_spi: assert property (@(posedge clk) disable iff (!rst_int_n)
    (st_q == ST_LAUNCH && !spi_strap_i) |=> (done_q && spi_cs_n_o));
  a_r6_fallback_flags_clear: assert property (@(posedge clk) disable iff (!rst_int_n)
    (valid_q && dec_q.src != SRC_SPI) |-> (!dec_q.addr24 && !dec_q.prot));
  a_r5_wide_implies_spi: assert property (@(posedge clk) disable iff (!rst_int_n)
    refetch24_o |-> (dec_q.src == SRC_SPI && dec_q.prot));
  a_r9_idle_deselected: assert property (@(posedge clk) disable iff (!rst_int_n)
    (st_q == ST_IDLE) |-> spi_cs_n_o);

endmodule

// File: tb/tb_eeprom_boot_probe.sv
module tb_eeprom_boot_probe;

  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 2;
  localparam int NVEC       = 10;
  localparam int WDOG       = 150000;

  // {spi_strap, nand_strap, header, exp_src, exp_a24, exp_prot}
  localparam logic [37:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 32'h564C5335, 2'd1, 1'b0, 1'b1},
    {1'b1, 1'b1, 32'h574C5335, 2'd1, 1'b0, 1'b0},
    {1'b1, 1'b0, 32'h41564C53, 2'd1, 1'b1, 1'b1},
    {1'b1, 1'b1, 32'h56564C53, 2'd1, 1'b1, 1'b1},
    {1'b1, 1'b1, 32'hFFFFFFFF, 2'd2, 1'b0, 1'b0},
    {1'b1, 1'b0, 32'hFFFFFFFF, 2'd0, 1'b0, 1'b0},
    {1'b1, 1'b0, 32'h564C5334, 2'd0, 1'b0, 1'b0},
    {1'b1, 1'b1, 32'h00574C53, 2'd2, 1'b0, 1'b0},
    {1'b0, 1'b1, 32'h564C5335, 2'd2, 1'b0, 1'b0},
    {1'b0, 1'b0, 32'h564C5335, 2'd0, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n, start, spi_strap, nand_strap, miso;
  logic cs_n, sck, mosi, busy, done, valid, a24, prot, refetch;
  logic [1:0] src;

  int tests = 0;
  int fails = 0;
  int cs_falls = 0;
  int done_cnt = 0;
  int bitcnt = 0;
  logic [23:0] mosi_rx = '0;
  logic [31:0] resp = '0;
  time last_rise = 0;
  time period = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_boot_probe #(.CLK_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .spi_strap_i(spi_strap),
    .nand_strap_i(nand_strap), .spi_cs_n_o(cs_n), .spi_sck_o(sck),
    .spi_mosi_o(mosi), .spi_miso_i(miso), .busy_o(busy), .done_o(done),
    .valid_o(valid), .boot_src_o(src), .addr24_o(a24), .prot_o(prot),
    .refetch24_o(refetch)
  );

  // EEPROM model, SPI mode 0
  always @(negedge cs_n) begin
    cs_falls++;
    bitcnt = 0;
    last_rise = 0;
    miso = 1'b1;
  end
  always @(posedge sck) if (!cs_n) begin
    if (bitcnt < 24) mosi_rx = {mosi_rx[22:0], mosi};
    if (last_rise != 0) period = $time - last_rise;
    last_rise = $time;
    bitcnt++;
  end
  always @(negedge sck) if (!cs_n) begin
    if (bitcnt >= 24 && bitcnt < 56) miso = resp[55-bitcnt];
    else miso = 1'b1;
  end
  always @(posedge clk) if (done) done_cnt++;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 2000 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  function automatic string tag_of(input logic [37:0] v);
    if (!v[37])          return "R1";
    if (v[1])            return "R5";
    if (v[3:2] != 2'd1)  return "R6";
    if (v[0])            return "R3";
    return "R4";
  endfunction

  initial begin
    #(WDOG * CLK_PERIOD);
    fails++;
    tests++;
    $display("FAIL watchdog actual=%0d expected=%0d", WDOG, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit seen;
    int falls0, dones0;
    logic [3:0] held;
    rst_n = 1'b0; start = 1'b0; miso = 1'b1;
    spi_strap = 1'b1; nand_strap = 1'b0; resp = 32'h564C5335;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(cs_n && !sck && !done && !valid && !busy, "R9 reset outputs",
          {27'd0, cs_n, sck, done, valid, busy}, 32'h10);
    rst_n = 1'b1;
    // R10 automatic run after reset
    wait_done(seen);
    check(seen, "R10 auto run done", seen, 1);
    check(src == 2'd1 && !a24 && prot, "R10 R3 auto decision", {src, a24, prot}, 4'b0101);
    check(cs_falls == 1, "R10 one frame", cs_falls, 1);

    for (int k = 0; k < NVEC; k++) begin
      falls0 = cs_falls;
      spi_strap = VEC[k][37];
      nand_strap = VEC[k][36];
      resp = VEC[k][35:4];
      mosi_rx = '0;
      pulse_start();
      wait_done(seen);
      check(seen && valid, {tag_of(VEC[k]), " done"}, {seen, valid}, 2'b11);
      check({src, a24, prot} == VEC[k][3:0], {tag_of(VEC[k]), " decision"},
            {src, a24, prot}, VEC[k][3:0]);
      check(refetch == VEC[k][1], {tag_of(VEC[k]), " R5 refetch"}, refetch, VEC[k][1]);
      if (VEC[k][37]) begin
        check(cs_falls == falls0 + 1, "R2 single frame", cs_falls - falls0, 1);
        check(mosi_rx == 24'h030000, "R2 command and address", mosi_rx, 24'h030000);
        check(period == 2 * DIV * CLK_PERIOD, "R2 SCK period", period, 2 * DIV * CLK_PERIOD);
      end else begin
        check(cs_falls == falls0, "R1 no SPI activity", cs_falls - falls0, 0);
      end
    end

    // R7: done one cycle, outputs held
    falls0 = cs_falls;
    spi_strap = 1'b1; nand_strap = 1'b0; resp = 32'h574C5335;
    pulse_start();
    wait_done(seen);
    held = {src, a24, prot};
    @(negedge clk);
    check(!done, "R7 done one cycle", done, 0);
    spi_strap = 1'b0; nand_strap = 1'b1; resp = 32'hFFFFFFFF;
    repeat (50) @(negedge clk);
    check(valid && {src, a24, prot} == held, "R7 decision held",
          {valid, src, a24, prot}, {1'b1, held});

    // R8: start while busy ignored
    spi_strap = 1'b1; nand_strap = 1'b0; resp = 32'h41564C53;
    dones0 = done_cnt;
    falls0 = cs_falls;
    pulse_start();
    @(negedge clk);
    check(busy && !valid, "R8 busy drops valid", {busy, valid}, 2'b10);
    repeat (40) @(negedge clk);
    pulse_start();
    repeat (30) @(negedge clk);
    pulse_start();
    wait_done(seen);
    repeat (300) @(negedge clk);
    check(cs_falls == falls0 + 1, "R8 one frame despite starts", cs_falls - falls0, 1);
    check(done_cnt == dones0 + 1, "R8 one done", done_cnt - dones0, 1);
    check(src == 2'd1 && a24, "R8 R5 decision", {src, a24}, 3'b011);

    // R9: reset mid-frame, then R10 restart with strap low
    pulse_start();
    repeat (40) @(negedge clk);
    rst_n = 1'b0;
    spi_strap = 1'b0; nand_strap = 1'b0;
    #1;
    check(cs_n && !sck && !valid && !busy, "R9 async abort",
          {28'd0, cs_n, sck, valid, busy}, 32'h8);
    repeat (2) @(negedge clk);
    falls0 = cs_falls;
    rst_n = 1'b1;
    wait_done(seen);
    check(seen && src == 2'd0, "R10 R1 restart to ROM", {seen, src}, 3'b100);
    check(cs_falls == falls0, "R1 no frame after reset", cs_falls - falls0, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule